// File: doc/BRIEF.md
# Interval Timer with Shadowed Compare Channels

The block is a periodic interval timer. A free-running up-counter advances on every system clock cycle in which the count-clock enable input is high. A period register sets the terminal count: when it holds D, the counter cycles through 0..D, so a period event occurs once every D+1 enabled cycles. Each period event raises a one-cycle interrupt pulse on channel 0.

Three further compare channels do not match against their programmed values directly. Each programmed value is first copied into a private shadow buffer, and only that buffer is compared with the count. The copy happens on every counter wrap and when the timer is started. Software can therefore change a compare value mid-period without disturbing the period in progress. Each channel's interrupt can be masked.

Four timer output pins each have an enable bit and an idle-level bit. A disabled pin drives its idle level. An enabled pin starts at that level and inverts on every period event. The counter value is available through a read-back register. Configuration uses a single-cycle register write port and a combinational read port.

Top module: `ivt_timer`

## Requirements
- R1: After reset every readable register (addresses 0 to 7) reads 0, and `irq` and `tout` are 0.
- R2: While the run bit (address 0, bit 0) is 0, the count read back at address 3 is 0, whatever `cnt_en` does.
- R3: While running, the count increases by one after each clock cycle with `cnt_en` high and holds after cycles with `cnt_en` low. It is read back at address 3.
- R4: With the period register (address 4) holding D, the counter goes from D to 0 on an enabled cycle, and `irq[0]` is high for exactly the one clock after that cycle.
- R5: For channel n in 1..3, `irq[n]` is high for the one clock after an enabled cycle in which the count equals that channel's shadow value. No interrupt follows a cycle with `cnt_en` low.
- R6: A compare value written at address 4+n (n in 1..3) affects matching only after the next wrap or after the run bit is next set from 0. Until then, the previous shadow value stays in use.
- R7: Mask register bit n (address 1, bits 3:0) set to 1 suppresses `irq[n]`.
- R8: A pin whose enable bit (address 2, bit p for pin p) is 0 drives its idle level (address 2, bit 4+p).
- R9: An enabled pin, while running, first shows its idle level and then inverts on each period event. Otherwise it does not change except through a register write.
- R10: The registers at addresses 0, 1, 2 and 4 to 7 read back the last value written to their fields. A write to address 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_en | input | 1 | Count-clock enable, one pulse per count step |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| irq | output | 4 | Interrupt pulses, bit 0 period, bits 1..3 compare channels |
| tout | output | 4 | Timer output pins |

## Verification
The assertions check on every cycle the things that depend on one step alone. These are: the counter clears when stopped, holds without enable, steps by one and wraps at the period. Interrupts never follow a disabled cycle, and a masked channel stays silent. Shadow buffers change only on a wrap or a start, and pins stay steady between period events.

Only the bench scenarios can show the longer-range behaviour. That means the exact D+1 spacing of period events across a sweep of small periods and enable patterns, and a compare value written mid-period taking effect one period later. They also cover the starting level of toggling pins and the read-back of every register.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  // Register address map
  localparam int unsigned REG_CTRL     = 0;
  localparam int unsigned REG_MASK     = 1;
  localparam int unsigned REG_PIN      = 2;
  localparam int unsigned REG_COUNT    = 3;
  localparam int unsigned REG_CMP_BASE = 4;
endpackage

// File: rtl/ivt_regs.sv
module ivt_regs
  import ivt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NCH    = 4,
  parameter int NPIN   = 4,
  parameter int ADDR_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [CNT_W-1:0]              wr_data,
  input  logic [ADDR_W-1:0]             rd_addr,
  input  logic [CNT_W-1:0]              cnt,
  output logic                          run,
  output logic                          start,
  output logic [NCH-1:0]                mask,
  output logic [NPIN-1:0]               pin_en,
  output logic [NPIN-1:0]               pin_lvl,
  output logic [NCH-1:0][CNT_W-1:0]     cmp,
  output logic [CNT_W-1:0]              rd_data
);

  logic                      run_q, run_d;
  logic [NCH-1:0]            mask_q, mask_d;
  logic [NPIN-1:0]           en_q, en_d, lvl_q, lvl_d;
  logic [NCH-1:0][CNT_W-1:0] cmp_q, cmp_d;

  // next-state: register writes
  always_comb begin
    run_d  = run_q;
    mask_d = mask_q;
    en_d   = en_q;
    lvl_d  = lvl_q;
    cmp_d  = cmp_q;
    if (wr_en) begin
      if (wr_addr == ADDR_W'(REG_CTRL)) run_d = wr_data[0];
      if (wr_addr == ADDR_W'(REG_MASK)) mask_d = wr_data[NCH-1:0];
      if (wr_addr == ADDR_W'(REG_PIN)) begin
        en_d  = wr_data[NPIN-1:0];
        lvl_d = wr_data[2*NPIN-1:NPIN];
      end
      for (int k = 0; k < NCH; k++) begin
        if (wr_addr == ADDR_W'(REG_CMP_BASE + k)) cmp_d[k] = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mask_q <= '0;
      en_q   <= '0;
      lvl_q  <= '0;
      cmp_q  <= '0;
    end else begin
      run_q  <= run_d;
      mask_q <= mask_d;
      en_q   <= en_d;
      lvl_q  <= lvl_d;
      cmp_q  <= cmp_d;
    end
  end

  // timer start: run bit written to 1 while stopped
  assign start = wr_en && (wr_addr == ADDR_W'(REG_CTRL)) && wr_data[0] && !run_q;

  // read mux
  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(REG_CTRL)) rd_data[0] = run_q;
    if (rd_addr == ADDR_W'(REG_MASK)) rd_data[NCH-1:0] = mask_q;
    if (rd_addr == ADDR_W'(REG_PIN)) begin
      rd_data[NPIN-1:0]      = en_q;
      rd_data[2*NPIN-1:NPIN] = lvl_q;
    end
    if (rd_addr == ADDR_W'(REG_COUNT)) rd_data = cnt;
    for (int k = 0; k < NCH; k++) begin
      if (rd_addr == ADDR_W'(REG_CMP_BASE + k)) rd_data = cmp_q[k];
    end
  end

  assign run     = run_q;
  assign mask    = mask_q;
  assign pin_en  = en_q;
  assign pin_lvl = lvl_q;
  assign cmp     = cmp_q;

endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             evt
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_end;

  assign at_end = (cnt_q == period);
  assign evt    = run && cnt_en && at_end;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)           cnt_d = '0;
    else if (cnt_en) begin
      if (at_end)       cnt_d = '0;
      else              cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/ivt_compare.sv
module ivt_compare #(
  parameter int CNT_W = 16,
  parameter int NCH   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run,
  input  logic                      cnt_en,
  input  logic                      evt,
  input  logic                      start,
  input  logic [CNT_W-1:0]          cnt,
  input  logic [NCH-1:0]            mask,
  input  logic [NCH-1:1][CNT_W-1:0] cmp,
  output logic [NCH-1:1][CNT_W-1:0] bufs,
  output logic [NCH-1:0]            irq
);

  logic           load;
  logic [NCH-1:0] irq_d, irq_q;

  assign load     = evt || start;
  assign irq_d[0] = evt && !mask[0];

  for (genvar g = 1; g < NCH; g++) begin : g_chan
    logic [CNT_W-1:0] buf_q, buf_d;

    always_comb begin
      buf_d = buf_q;
      if (load) buf_d = cmp[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) buf_q <= '0;
      else        buf_q <= buf_d;
    end

    assign irq_d[g] = run && cnt_en && (cnt == buf_q) && !mask[g];
    assign bufs[g]  = buf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

endmodule

// File: rtl/ivt_pins.sv
module ivt_pins #(
  parameter int NPIN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            evt,
  input  logic [NPIN-1:0] pin_en,
  input  logic [NPIN-1:0] pin_lvl,
  output logic [NPIN-1:0] tout
);

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic tog_q, tog_d;

    always_comb begin
      tog_d = tog_q;
      if (!pin_en[g] || !run) tog_d = pin_lvl[g];
      else if (evt)           tog_d = !tog_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tog_q <= 1'b0;
      else        tog_q <= tog_d;
    end

    assign tout[g] = pin_en[g] ? tog_q : pin_lvl[g];
  end

endmodule

// File: rtl/ivt_timer.sv
module ivt_timer #(
  parameter  int CNT_W  = 16,
  parameter  int NCMP   = 3,
  parameter  int NPIN   = 4,
  localparam int NCH    = NCMP + 1,
  localparam int ADDR_W = $clog2(NCH + 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic [NCH-1:0]    irq,
  output logic [NPIN-1:0]   tout
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync = rst_pipe[1];

  logic                      run, start, evt;
  logic [NCH-1:0]            mask;
  logic [NPIN-1:0]           pin_en, pin_lvl;
  logic [NCH-1:0][CNT_W-1:0] cmp;
  logic [NCH-1:1][CNT_W-1:0] bufs;
  logic [CNT_W-1:0]          cnt, period;

  assign period = cmp[0];

  ivt_regs #(.CNT_W(CNT_W), .NCH(NCH), .NPIN(NPIN), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_sync), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .cnt(cnt), .run(run), .start(start), .mask(mask),
    .pin_en(pin_en), .pin_lvl(pin_lvl), .cmp(cmp), .rd_data(rd_data)
  );

  ivt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_sync), .run(run), .cnt_en(cnt_en), .period(period),
    .cnt(cnt), .evt(evt)
  );

  ivt_compare #(.CNT_W(CNT_W), .NCH(NCH)) u_compare (
    .clk(clk), .rst_n(rst_sync), .run(run), .cnt_en(cnt_en), .evt(evt), .start(start),
    .cnt(cnt), .mask(mask), .cmp(cmp[NCH-1:1]), .bufs(bufs), .irq(irq)
  );

  ivt_pins #(.NPIN(NPIN)) u_pins (
    .clk(clk), .rst_n(rst_sync), .run(run), .evt(evt), .pin_en(pin_en),
    .pin_lvl(pin_lvl), .tout(tout)
  );

endmodule

// File: rtl/ivt_chk.sv
module ivt_chk #(
  parameter int CNT_W = 16,
  parameter int NCH   = 4,
  parameter int NPIN  = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      run,
  input logic                      cnt_en,
  input logic                      wr_en,
  input logic                      evt,
  input logic                      start,
  input logic [CNT_W-1:0]          cnt,
  input logic [CNT_W-1:0]          period,
  input logic [NCH-1:0]            mask,
  input logic [NCH-1:1][CNT_W-1:0] bufs,
  input logic [NCH-1:0]            irq,
  input logic [NPIN-1:0]           tout
);

  // R2
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_en) |=> $stable(cnt));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_en && (cnt != period)) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_en && (cnt == period)) |=> (cnt == '0));

  // R4
  period_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_en && (cnt == period) && !mask[0]) |=> irq[0]);

  // R5
  irq_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> (irq == '0));

  // R7
  mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & $past(mask)) == '0);

  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt || start) |=> $stable(bufs));

  // R9
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !evt && !wr_en) |=> $stable(tout));

endmodule

bind ivt_timer ivt_chk #(.CNT_W(CNT_W), .NCH(NCH), .NPIN(NPIN)) i_chk (
  .clk(clk), .rst_n(rst_sync), .run(run), .cnt_en(cnt_en), .wr_en(wr_en),
  .evt(evt), .start(start), .cnt(cnt), .period(period), .mask(mask),
  .bufs(bufs), .irq(irq), .tout(tout)
);

// File: tb/test_ivt_timer.sv
module test_ivt_timer;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = 3'd3;
  logic [15:0] rd_data;
  logic [3:0]  irq;
  logic [3:0]  tout;

  ivt_timer i_ivt_timer (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .tout(tout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 1'b0;

  // behavioural expectations, derived from the requirements
  logic        m_run = 1'b0;
  logic [15:0] m_cnt = '0;
  logic [15:0] m_cmp [4];
  logic [15:0] m_buf [4];
  logic [3:0]  m_mask = '0, m_en = '0, m_lvl = '0, m_tog = '0, m_irq = '0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic        evt, start;
    logic [3:0]  nirq, ntog;
    logic [15:0] ncnt;
    evt     = m_run && cnt_en && (m_cnt == m_cmp[0]);
    start   = wr_en && (wr_addr == 3'd0) && wr_data[0] && !m_run;
    nirq[0] = evt && !m_mask[0];
    for (int k = 1; k < 4; k++) nirq[k] = m_run && cnt_en && (m_cnt == m_buf[k]) && !m_mask[k];
    for (int p = 0; p < 4; p++)
      ntog[p] = (!m_en[p] || !m_run) ? m_lvl[p] : (evt ? !m_tog[p] : m_tog[p]);
    if (!m_run)      ncnt = '0;
    else if (cnt_en) ncnt = evt ? 16'd0 : m_cnt + 16'd1;
    else             ncnt = m_cnt;
    if (evt || start) for (int k = 1; k < 4; k++) m_buf[k] = m_cmp[k];
    m_irq = nirq; m_tog = ntog; m_cnt = ncnt;
    if (wr_en) begin
      case (wr_addr)
        3'd0: m_run = wr_data[0];
        3'd1: m_mask = wr_data[3:0];
        3'd2: begin m_en = wr_data[3:0]; m_lvl = wr_data[7:4]; end
        3'd3: ;
        default: m_cmp[wr_addr - 3'd4] = wr_data;
      endcase
    end
  endtask

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    if (rd_addr == 3'd3) check("R3 count", rd_data, m_cnt);
    check("R4 period irq", irq[0], m_irq[0]);
    check("R5/R7 compare irq", irq[3:1], m_irq[3:1]);
    check("R8 idle level", tout & ~m_en, m_lvl & ~m_en);
    check("R9 toggle", tout & m_en, m_tog & m_en);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd_expect(string tag, logic [2:0] a, logic [15:0] exp);
    rd_addr = a;
    #1;
    check(tag, rd_data, exp);
    rd_addr = 3'd3;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n1, n2;
    for (int k = 0; k < 4; k++) begin m_cmp[k] = '0; m_buf[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset values
    for (int a = 0; a < 8; a++) rd_expect("R1 reset register", 3'(a), 16'h0);
    check("R1 reset irq", irq, 4'h0);
    check("R1 reset tout", tout, 4'h0);

    // R10: register read-back, count not writable
    wr(3'd1, 16'h000A);
    wr(3'd2, 16'h0035);
    for (int k = 0; k < 4; k++) wr(3'(4 + k), 16'h1111 * 16'(k + 1));
    rd_expect("R10 mask", 3'd1, 16'h000A);
    rd_expect("R10 pin", 3'd2, 16'h0035);
    for (int k = 0; k < 4; k++) rd_expect("R10 compare", 3'(4 + k), 16'h1111 * 16'(k + 1));
    wr(3'd3, 16'hFFFF);
    rd_expect("R10 count write ignored", 3'd3, 16'h0);
    wr(3'd0, 16'h0001);
    rd_expect("R10 run", 3'd0, 16'h0001);
    wr(3'd0, 16'h0000);

    // sweep: periods 0..6, three enable/mask patterns
    for (int d = 0; d < 7; d++) begin
      for (int mode = 0; mode < 3; mode++) begin
        cnt_en = 1'b0;
        wr(3'd4, 16'(d));
        wr(3'd5, 16'd0);
        wr(3'd6, 16'(d));
        wr(3'd7, 16'(d + 1));
        wr(3'd1, (mode == 1) ? 16'h0006 : 16'h0000);
        wr(3'd2, (mode == 2) ? 16'h00A3 : 16'h0035);
        wr(3'd0, 16'h0001);
        for (int i = 0; i < 8 * (d + 1) + 6; i++) begin
          cnt_en = (mode == 2) ? ((i % 3) != 1) : 1'b1;
          if (i == d + 2) wr(3'd5, 16'(d));
          else tick();
        end
        cnt_en = 1'b1;
        wr(3'd0, 16'h0000);
        repeat (3) tick();
        rd_expect("R2 stopped count", 3'd3, 16'h0);
      end
    end

    // R6: compare write mid-period takes effect next period
    cnt_en = 1'b1;
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'h0000);
    wr(3'd4, 16'd9);
    wr(3'd5, 16'd2);
    wr(3'd0, 16'h0001);
    while (rd_data != 16'd4) tick();
    wr(3'd5, 16'd7);
    n1 = 0;
    while (rd_data != 16'd0) begin tick(); if (irq[1]) n1++; end
    check("R6 old shadow kept in period", n1, 0);
    n2 = 0;
    for (int i = 0; i < 10; i++) begin tick(); if (irq[1]) n2++; end
    check("R6 new shadow after wrap", n2, 1);
    check("R4 back at zero after one period", rd_data, 16'd0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule